// File: doc/BRIEF.md
# Two-Pin PWM Audio Output Stage

This block turns an 8-bit audio sample written by a processor into a pulse-width modulated carrier on two speaker pins. A carrier period is 128 counts of a 7-bit counter, and each count lasts `PRESCALE` system clocks. In every period a pin is high while the counter is below the sample magnitude. The processor writes the sample at any time. The stage takes a new sample only at a sample-rate boundary, so a sample that is not rewritten simply plays again. One sample spans several carrier periods, and the number of periods depends on the rate code.

In the default two-pin mode the sample is sign-magnitude. Bit 7 chooses the pin and bits 6..0 give the magnitude, while the other pin stays low. In single-pin mode bits 7..1 form the magnitude and only the first pin is driven. A three-state machine sequences the stage:
- `ST_IDLE`: pins low, counter cleared.
- `ST_RUN`: carrier active.
- `ST_DRAIN`: a stop has been requested and the current period is finishing.

The transitions are:
- *start*: `ST_IDLE`→`ST_RUN`, when the run bit is 1 and the rate code is valid. The pending sample is latched.
- *stop_req*: `ST_RUN`→`ST_DRAIN`, when the run bit is cleared in mid-period.
- *stop_now*: `ST_RUN`→`ST_IDLE`, when the run bit is cleared in the last tick of a period.
- *resume*: `ST_DRAIN`→`ST_RUN`, when the run bit is set again.
- *drain_done*: `ST_DRAIN`→`ST_IDLE`, at the end of the period.
- *kill*: `ST_RUN`/`ST_DRAIN`→`ST_IDLE`, on rate code 3.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset both pins are low, the state is idle and `ctrl_q` reads 0x00.
- R2: Control fields are: bit 0 run, bit 2 voice-memory enable, bit 3 single-pin mode, and bits 6..5 rate code. Bits 1, 4 and 7 always read 0, so writing 0xFF reads back 0x6D.
- R3: Writing the run bit to 1 while idle, with a rate code other than 3, starts the carrier. The pending sample is latched at that moment.
- R4: Each carrier period lasts 128*`PRESCALE` clocks. The active pin is high for exactly magnitude*`PRESCALE` clocks of it, so magnitude 0 never goes high and 127 is high for 127 counts.
- R5: In two-pin mode, sign bit 7 = 0 drives `spk_a` with `spk_b` low, and sign 1 drives `spk_b` with `spk_a` low. The pins are never high together.
- R6: In single-pin mode (bit 3 = 1) the magnitude is sample bits 7..1, output on `spk_a` only, and `spk_b` stays low.
- R7: With rate code 2 the magnitude is clamped to 124. Codes 0 and 1 allow up to 127.
- R8: A sample spans 6, 5 or 4 carrier periods for rate codes 0, 1 and 2. A new sample is taken only at the end of the last of them, and the previous one repeats if no write occurred.
- R9: Clearing the run bit lets the current carrier period finish with its full width. Both pins then stay low.
- R10: Rate code 3 forces both pins low at once and returns the stage to idle.
- R11: The voice-memory enable bit is stored and read back but has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wd | input | 8 | Control register write data |
| smp_we | input | 1 | Sample register write strobe |
| smp_wd | input | 8 | Sample register write data |
| ctrl_q | output | 8 | Control register readback |
| spk_a | output | 1 | First speaker pin (positive half / single-pin output) |
| spk_b | output | 1 | Second speaker pin (negative half) |

## Verification
Two pairs of events can fall in the same cycle.
- **Sample write and boundary latch.** A processor sample write can arrive in the same cycle as the sample-boundary latch. Writes are placed at fixed and random offsets inside a sample. The high width of every following carrier period is measured, and a period must carry either the whole old or the whole new magnitude. The change must come exactly after the 6th, 5th or 4th period.
- **Stop request and period wrap.** A stop request can arrive in the same cycle as the counter wrap. Stops are issued inside the high part and inside the low part of a period. The total high time after the stop must equal one full width, or zero. A checker also holds that a drain ending at the wrap leads to idle.

// File: rtl/pwm_audio_dac_pkg.sv
package pwm_audio_dac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } dac_state_e;

    localparam logic [1:0] RATE_SLOW = 2'd0;
    localparam logic [1:0] RATE_MID  = 2'd1;
    localparam logic [1:0] RATE_FAST = 2'd2;
    localparam logic [1:0] RATE_OFF  = 2'd3;

    localparam int BIT_RUN    = 0;
    localparam int BIT_VMEM   = 2;
    localparam int BIT_SINGLE = 3;
    localparam int BIT_RATE   = 5;

endpackage

// File: rtl/pwm_audio_dac_tick.sv
module pwm_audio_dac_tick #(
    parameter int PRESCALE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_audio_dac_regs.sv
module pwm_audio_dac_regs
    import pwm_audio_dac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wd,
    input  logic       smp_we,
    input  logic [7:0] smp_wd,
    output logic [7:0] ctrl_q,
    output logic [7:0] smp_q,
    output logic       run_bit,
    output logic       single,
    output logic [1:0] rate
);
    logic vmem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_bit <= 1'b0;
            vmem_q  <= 1'b0;
            single  <= 1'b0;
            rate    <= RATE_SLOW;
        end else if (ctrl_we) begin
            run_bit <= ctrl_wd[BIT_RUN];
            vmem_q  <= ctrl_wd[BIT_VMEM];
            single  <= ctrl_wd[BIT_SINGLE];
            rate    <= ctrl_wd[BIT_RATE+1:BIT_RATE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else if (smp_we) begin
            smp_q <= smp_wd;
        end
    end

    always_comb begin
        ctrl_q                        = '0;
        ctrl_q[BIT_RUN]               = run_bit;
        ctrl_q[BIT_VMEM]              = vmem_q;
        ctrl_q[BIT_SINGLE]            = single;
        ctrl_q[BIT_RATE+1:BIT_RATE]   = rate;
    end
endmodule

// File: rtl/pwm_audio_dac_fsm.sv
module pwm_audio_dac_fsm
    import pwm_audio_dac_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int REP_SLOW = 6,
    parameter int REP_MID  = 5,
    parameter int REP_FAST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_bit,
    input  logic [1:0]       rate,
    output dac_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             latch,
    output logic             active
);
    localparam int REP_MAX = (REP_SLOW > REP_MID) ?
                             ((REP_SLOW > REP_FAST) ? REP_SLOW : REP_FAST) :
                             ((REP_MID > REP_FAST) ? REP_MID : REP_FAST);
    localparam int REP_W = $clog2(REP_MAX + 1);
    localparam logic [REP_W-1:0] TGT_SLOW = REP_W'(REP_SLOW - 1);
    localparam logic [REP_W-1:0] TGT_MID  = REP_W'(REP_MID - 1);
    localparam logic [REP_W-1:0] TGT_FAST = REP_W'(REP_FAST - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;

    dac_state_e       nxt;
    logic [REP_W-1:0] rep_q;
    logic [REP_W-1:0] tgt;
    logic             period_end;
    logic             rate_ok;
    logic             start;

    always_comb begin
        unique case (rate)
            RATE_SLOW: tgt = TGT_SLOW;
            RATE_MID:  tgt = TGT_MID;
            default:   tgt = TGT_FAST;
        endcase
    end

    assign period_end = tick && (cnt == CNT_TOP);
    assign rate_ok    = (rate != RATE_OFF);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (run_bit && rate_ok) nxt = ST_RUN;            // start
            end
            ST_RUN: begin
                if (!rate_ok)                    nxt = ST_IDLE;  // kill
                else if (!run_bit && period_end) nxt = ST_IDLE;  // stop_now
                else if (!run_bit)               nxt = ST_DRAIN; // stop_req
            end
            ST_DRAIN: begin
                if (!rate_ok)        nxt = ST_IDLE;              // kill
                else if (run_bit)    nxt = ST_RUN;               // resume
                else if (period_end) nxt = ST_IDLE;              // drain_done
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign start  = (state == ST_IDLE) && (nxt == ST_RUN);
    assign active = (state != ST_IDLE);

    // outputs of the sequencer: duty counter, repeat counter, latch strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rep_q <= '0;
        end else if (state == ST_IDLE) begin
            cnt   <= '0;
            rep_q <= '0;
        end else begin
            if (tick) cnt <= cnt + 1'b1;
            if (state == ST_RUN && period_end) begin
                rep_q <= (rep_q >= tgt) ? '0 : rep_q + 1'b1;
            end
        end
    end

    assign latch = start || ((state == ST_RUN) && period_end && (rep_q >= tgt));
endmodule

// File: rtl/pwm_audio_dac_steer.sv
module pwm_audio_dac_steer
    import pwm_audio_dac_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int FAST_MAX = 124
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch,
    input  logic [7:0]       smp_q,
    input  logic             single,
    input  logic [1:0]       rate,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       cur_smp,
    output logic             spk_a,
    output logic             spk_b
);
    localparam logic [CNT_W-1:0] CLAMP = CNT_W'(FAST_MAX);

    logic [CNT_W-1:0] mag;
    logic             hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cur_smp <= '0;
        else if (latch) cur_smp <= smp_q;
    end

    always_comb begin
        mag = single ? cur_smp[7:1] : cur_smp[6:0];
        if (rate == RATE_FAST && mag > CLAMP) mag = CLAMP;
        hi    = active && (rate != RATE_OFF) && (cnt < mag);
        spk_a = hi && (single || !cur_smp[7]);
        spk_b = hi && !single && cur_smp[7];
    end
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
    import pwm_audio_dac_pkg::*;
#(
    parameter int PRESCALE = 2,
    parameter int CNT_W    = 7,
    parameter int REP_SLOW = 6,
    parameter int REP_MID  = 5,
    parameter int REP_FAST = 4,
    parameter int FAST_MAX = 124
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wd,
    input  logic       smp_we,
    input  logic [7:0] smp_wd,
    output logic [7:0] ctrl_q,
    output logic       spk_a,
    output logic       spk_b
);
    logic             run_bit;
    logic             single;
    logic [1:0]       rate;
    logic [7:0]       smp_q;
    logic [7:0]       cur_smp;
    logic             tick_w;
    logic             latch_w;
    logic             active_w;
    logic [CNT_W-1:0] cnt_q;
    dac_state_e       st_q;

    pwm_audio_dac_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .smp_we(smp_we), .smp_wd(smp_wd),
        .ctrl_q(ctrl_q), .smp_q(smp_q),
        .run_bit(run_bit), .single(single), .rate(rate)
    );

    pwm_audio_dac_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(active_w), .tick(tick_w)
    );

    pwm_audio_dac_fsm #(
        .CNT_W(CNT_W), .REP_SLOW(REP_SLOW), .REP_MID(REP_MID), .REP_FAST(REP_FAST)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick_w),
        .run_bit(run_bit), .rate(rate),
        .state(st_q), .cnt(cnt_q), .latch(latch_w), .active(active_w)
    );

    pwm_audio_dac_steer #(.CNT_W(CNT_W), .FAST_MAX(FAST_MAX)) u_steer (
        .clk(clk), .rst_n(rst_n), .latch(latch_w), .smp_q(smp_q),
        .single(single), .rate(rate), .active(active_w), .cnt(cnt_q),
        .cur_smp(cur_smp), .spk_a(spk_a), .spk_b(spk_b)
    );
endmodule

// File: rtl/pwm_audio_dac_chk.sv
module pwm_audio_dac_chk
    import pwm_audio_dac_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl_q,
    input logic             spk_a,
    input logic             spk_b,
    input dac_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic             tick,
    input logic             latch,
    input logic [7:0]       cur_smp
);
    localparam logic [CNT_W-1:0] TOP = '1;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!spk_a && !spk_b));

    a_r5_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !(spk_a && spk_b));

    a_r6_single_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[BIT_SINGLE] |-> !spk_b);

    a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[BIT_RATE+1:BIT_RATE] == RATE_OFF) |-> (!spk_a && !spk_b));

    a_r8_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_smp) |-> $past(latch));

    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !tick) |=> $stable(cnt));

    a_r9_drain_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DRAIN) && tick && (cnt == TOP) && !ctrl_q[BIT_RUN])
        |=> (state == ST_IDLE));
endmodule

bind pwm_audio_dac pwm_audio_dac_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .spk_a(spk_a), .spk_b(spk_b),
    .state(st_q), .cnt(cnt_q), .tick(tick_w), .latch(latch_w), .cur_smp(cur_smp)
);

// File: tb/pwm_audio_dac_tb_top.sv
`timescale 1ns/1ps
module pwm_audio_dac_tb_top;
    localparam int DIV = 2;
    localparam int PER = 128 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wd = '0;
    logic       smp_we = 1'b0;
    logic [7:0] smp_wd = '0;
    logic [7:0] ctrl_q;
    logic       spk_a, spk_b;

    int checks = 0;
    int errors = 0;
    int hc_a = 0;
    int hc_b = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwm_audio_dac dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .smp_we(smp_we), .smp_wd(smp_wd), .ctrl_q(ctrl_q),
        .spk_a(spk_a), .spk_b(spk_b)
    );

    always @(negedge clk) begin
        if (spk_a) hc_a++;
        if (spk_b) hc_b++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mkctl(input bit run, input bit vm, input bit sg, input logic [1:0] rt);
        return {1'b0, rt, 1'b0, sg, vm, 1'b0, run};
    endfunction

    function automatic int exp_mag(input logic [7:0] s, input bit sg, input logic [1:0] rt);
        int m;
        m = sg ? int'(s[7:1]) : int'(s[6:0]);
        if (rt == 2'd2 && m > 124) m = 124;
        if (rt == 2'd3) m = 0;
        return m;
    endfunction

    function automatic int reps(input logic [1:0] rt);
        return (rt == 2'd0) ? 6 : (rt == 2'd1) ? 5 : 4;
    endfunction

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wd = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_smp(input logic [7:0] v);
        @(negedge clk); smp_we = 1'b1; smp_wd = v;
        @(negedge clk); smp_we = 1'b0;
    endtask

    task automatic halt_out();
        wr_ctrl(8'h00);
        repeat (PER + 8) @(negedge clk);
    endtask

    // steady duty over one full carrier window (R4, R5, R6, R7, R11)
    task automatic steady(input logic [7:0] s, input bit sg, input logic [1:0] rt,
                          input bit vm, input string req);
        int ha, hb, m;
        halt_out();
        wr_smp(s);
        wr_ctrl(mkctl(1'b1, vm, sg, rt));
        repeat (10) @(negedge clk);
        ha = 0; hb = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (spk_a) ha++;
            if (spk_b) hb++;
        end
        m = exp_mag(s, sg, rt) * DIV;
        if (sg || !s[7]) begin
            chk(ha == m, {req, " pin a width"}, ha, m);
            chk(hb == 0, {req, " pin b quiet"}, hb, 0);
        end else begin
            chk(hb == m, {req, " pin b width"}, hb, m);
            chk(ha == 0, {req, " pin a quiet"}, ha, 0);
        end
    endtask

    // period-by-period widths around a sample update (R3, R8)
    task automatic seq_test(input logic [1:0] rt, input logic [6:0] m1, input logic [6:0] m2);
        int n, w;
        n = reps(rt);
        halt_out();
        wr_smp({1'b0, m1});
        wr_ctrl(mkctl(1'b1, 1'b0, 1'b0, rt));
        for (int p = 0; p < n + 2; p++) begin
            while (!spk_a) @(negedge clk);
            w = 0;
            while (spk_a) begin w++; @(negedge clk); end
            if (p < n) chk(w == int'(m1) * DIV, "R8 old sample repeats", w, int'(m1) * DIV);
            else       chk(w == int'(m2) * DIV, "R8 new sample at boundary", w, int'(m2) * DIV);
            if (p == 1) wr_smp({1'b0, m2});
        end
    endtask

    initial begin
        int c0, seed;
        logic [7:0] s;
        logic [1:0] rt;
        bit sg, vm;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(spk_a == 1'b0 && spk_b == 1'b0, "R1 pins low in reset", int'(spk_a | spk_b), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ctrl_q == 8'h00, "R1 control reads zero", int'(ctrl_q), 0);
        chk(spk_a == 1'b0 && spk_b == 1'b0, "R1 pins low after reset", int'(spk_a | spk_b), 0);

        // R2 layout and unused bits
        wr_ctrl(8'hFF);
        chk(ctrl_q == 8'h6D, "R2 unused bits read zero", int'(ctrl_q), 8'h6D);
        repeat (PER) @(negedge clk);
        chk(spk_a == 1'b0 && spk_b == 1'b0, "R10 rate 3 keeps pins low", int'(spk_a | spk_b), 0);
        halt_out();

        // directed duty corners
        steady(8'h28, 1'b0, 2'd0, 1'b0, "R4 R5 positive");
        steady(8'h85, 1'b0, 2'd0, 1'b0, "R5 negative");
        steady(8'h00, 1'b0, 2'd1, 1'b0, "R4 zero magnitude");
        steady(8'h7F, 1'b0, 2'd0, 1'b0, "R4 full magnitude");
        steady(8'h7F, 1'b0, 2'd2, 1'b0, "R7 clamp 124");
        steady(8'hFF, 1'b0, 2'd1, 1'b0, "R7 no clamp rate 1");
        steady(8'h85, 1'b1, 2'd0, 1'b0, "R6 single pin");
        steady(8'h85, 1'b0, 2'd0, 1'b1, "R11 voice bit no effect");
        chk(ctrl_q[2] == 1'b1, "R11 voice bit stored", int'(ctrl_q[2]), 1);

        // R3 R8 preload counts
        seq_test(2'd0, 7'd20, 7'd50);
        seq_test(2'd1, 7'd33, 7'd9);
        seq_test(2'd2, 7'd5, 7'd60);

        // R9 stop inside the high part: full width, then low
        halt_out();
        wr_smp(8'h28);
        wr_ctrl(mkctl(1'b1, 1'b0, 1'b0, 2'd0));
        while (!spk_a) @(negedge clk);
        while (spk_a) @(negedge clk);
        c0 = hc_a;
        while (!spk_a) @(negedge clk);
        repeat (10) @(negedge clk);
        wr_ctrl(mkctl(1'b0, 1'b0, 1'b0, 2'd0));
        repeat (3 * PER) @(negedge clk);
        chk(hc_a - c0 == 40 * DIV, "R9 stop finishes period", hc_a - c0, 40 * DIV);
        chk(spk_a == 1'b0, "R9 low after stop", int'(spk_a), 0);

        // R9 stop inside the low part: nothing more
        wr_ctrl(mkctl(1'b1, 1'b0, 1'b0, 2'd0));
        while (!spk_a) @(negedge clk);
        while (spk_a) @(negedge clk);
        c0 = hc_a;
        repeat (20) @(negedge clk);
        wr_ctrl(mkctl(1'b0, 1'b0, 1'b0, 2'd0));
        repeat (3 * PER) @(negedge clk);
        chk(hc_a - c0 == 0, "R9 stop in low part", hc_a - c0, 0);

        // R10 rate 3 while running kills output at once
        wr_ctrl(mkctl(1'b1, 1'b0, 1'b0, 2'd0));
        while (!spk_a) @(negedge clk);
        wr_ctrl(mkctl(1'b1, 1'b0, 1'b0, 2'd3));
        chk(spk_a == 1'b0, "R10 kill immediate", int'(spk_a), 0);
        c0 = hc_a;
        repeat (2 * PER) @(negedge clk);
        chk(hc_a - c0 == 0, "R10 stays idle", hc_a - c0, 0);

        // random duty patterns
        for (int k = 0; k < 10; k++) begin
            s  = 8'($urandom);
            rt = 2'($urandom % 3);
            sg = 1'($urandom);
            vm = 1'($urandom);
            steady(s, sg, rt, vm, "R4 R5 R6 R7 random");
        end
        // random sample-update sequences
        for (int k = 0; k < 3; k++) begin
            seq_test(2'($urandom % 3), 7'(1 + $urandom % 60), 7'(1 + $urandom % 60));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule